// File: doc/BRIEF.md
# Raster Timing Generator with Block Pixel Upscaler

This block produces a complete 640x480 progressive raster at a pixel clock of about 25 MHz. Each scan line is 800 clocks: 640 visible pixels, a 16-pixel front porch, a 96-pixel sync pulse and a 48-pixel back porch. Each frame is 525 lines: 480 visible lines, a 10-line front porch, a 2-line sync pulse and a 33-line back porch. Scanning starts at the top-left pixel, runs left to right and then moves down one line at a time.

The picture comes from a small monochrome frame store of 80x60 samples. The block reads that store through a single synchronous-read port and replicates each sample over a square of 8x8 screen pixels. The store address is presented one clock before the pixel it belongs to, so the read data arrives in step with the registered coordinates and sync flags. The intensity output is forced to zero whenever the beam is outside the visible area.

The source width, the source height, the scale shift and every porch and sync length are parameters. The visible size and the totals are derived from them, so an imager with a different array size needs only a change of parameters.

Top module: `vga_upscaler`

## Requirements
- R1: The horizontal sync output is active low. It is 0 exactly for screen columns H_VIS+H_FP up to H_VIS+H_FP+H_SYNC-1 (656..751 by default) and 1 for every other column. A line is H_TOT columns (800 by default).
- R2: The vertical sync output is active low. It is 0 exactly on lines V_VIS+V_FP up to V_VIS+V_FP+V_SYNC-1 (490..491 by default) and 1 on every other line. A frame is V_TOT lines (525 by default).
- R3: The display-enable output is 1 exactly when the reported column is below H_VIS (SRC_W<<SCALE_LOG2) and the reported line is below V_VIS (SRC_H<<SCALE_LOG2).
- R4: The intensity output is 0 on every cycle in which display-enable is 0.
- R5: The reported column steps by one on each clock and wraps from H_TOT-1 to 0. When the column wraps, the line steps by one, and the line wraps from V_TOT-1 to 0.
- R6: For a visible screen position (x, y), the frame-store address is (y>>SCALE_LOG2)*SRC_W + (x>>SCALE_LOG2).
- R7: The address is presented one clock before its position is reported. The intensity output on a visible cycle equals the store word at the address of the reported position, read with one clock of latency.
- R8: The frame-store address is 0 whenever the position it is issued for is outside the visible area.
- R9: While reset is asserted (asynchronous, active low), the reported position is (H_TOT-1, V_TOT-1), both syncs are 1, display-enable is 0 and the address is 0. The first clock after reset is released reports position (0, 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_addr_o | output | AW | Frame-store read address, one clock ahead of the pixel |
| rd_data_i | input | PIX_W | Frame-store read data, valid one clock after the address |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| de_o | output | 1 | High on visible pixels |
| x_o | output | XW | Current screen column |
| y_o | output | YW | Current screen line |
| pix_o | output | PIX_W | Gray level, zero outside the visible area |

## Verification
The bench targets the cycles where two counters change together. At the last column of a line the line counter must advance. At the end of the last line both counters must return to zero. Where the address row base steps, every eighth line, a wrong condition shifts a whole band of the picture by one source row. A design that issued the address in the same cycle as the pixel would show each 8-pixel block one column late, so the model compares the intensity at every block edge. The sync window edges and the visible edge are compared cycle by cycle, which exposes an off-by-one porch length. The first visible pixel after a mid-frame reset is also checked, which exposes a reset state that does not line up with the first fetch.

// File: rtl/vgu_pkg.sv
package vgu_pkg;

    typedef struct packed {
        logic hs_n;
        logic vs_n;
        logic de;
    } vgu_sync_t;

    localparam vgu_sync_t SYNC_IDLE = '{hs_n: 1'b1, vs_n: 1'b1, de: 1'b0};

    // half-open span test on a counter value
    function automatic logic in_span(input logic [15:0] v,
                                     input logic [15:0] lo,
                                     input logic [15:0] hi);
        return (v >= lo) && (v < hi);
    endfunction

endpackage

// File: rtl/vgu_raster.sv
module vgu_raster #(
    parameter int H_TOT = 800,
    parameter int V_TOT = 525,
    parameter int XW    = 10,
    parameter int YW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [XW-1:0] x,
    output logic [YW-1:0] y,
    output logic          line_last,
    output logic          frame_last
);
    typedef struct packed {
        logic [XW-1:0] x;
        logic [YW-1:0] y;
    } pos_t;

    pos_t pos_d, pos_q;

    assign line_last  = (pos_q.x == XW'(H_TOT - 1));
    assign frame_last = line_last && (pos_q.y == YW'(V_TOT - 1));

    always_comb begin
        pos_d = pos_q;
        if (line_last) begin
            pos_d.x = '0;
            pos_d.y = frame_last ? '0 : pos_q.y + YW'(1);
        end else begin
            pos_d.x = pos_q.x + XW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign x = pos_q.x;
    assign y = pos_q.y;
endmodule

// File: rtl/vgu_fetch.sv
module vgu_fetch #(
    parameter int SRC_W      = 80,
    parameter int SCALE_LOG2 = 3,
    parameter int H_VIS      = 640,
    parameter int V_VIS      = 480,
    parameter int XW         = 10,
    parameter int YW         = 10,
    parameter int AW         = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  logic          line_last,
    input  logic          frame_last,
    output logic [AW-1:0] rd_addr
);
    typedef struct packed {
        logic [AW-1:0] row_base;
    } fetch_t;

    fetch_t st_d, st_q;
    logic [YW:0]   y_inc;
    logic          visible;
    logic [XW-1:0] col;

    assign y_inc   = {1'b0, y} + (YW+1)'(1);
    assign visible = (x < XW'(H_VIS)) && (y < YW'(V_VIS));
    assign col     = x >> SCALE_LOG2;

    always_comb begin
        st_d = st_q;
        if (frame_last) begin
            st_d.row_base = '0;
        end else if (line_last && (y_inc[SCALE_LOG2-1:0] == '0)
                     && (y_inc < (YW+1)'(V_VIS))) begin
            st_d.row_base = st_q.row_base + AW'(SRC_W);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // issued from the counter, one clock ahead of the registered pixel stage
    assign rd_addr = visible ? (st_q.row_base + AW'(col)) : '0;
endmodule

// File: rtl/vgu_out_stage.sv
module vgu_out_stage
    import vgu_pkg::*;
#(
    parameter int H_VIS  = 640,
    parameter int V_VIS  = 480,
    parameter int H_FP   = 16,
    parameter int H_SYNC = 96,
    parameter int V_FP   = 10,
    parameter int V_SYNC = 2,
    parameter int H_TOT  = 800,
    parameter int V_TOT  = 525,
    parameter int XW     = 10,
    parameter int YW     = 10,
    parameter int PIX_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [XW-1:0]    x,
    input  logic [YW-1:0]    y,
    input  logic [PIX_W-1:0] rd_data,
    output logic [XW-1:0]    x_o,
    output logic [YW-1:0]    y_o,
    output logic             hs_n,
    output logic             vs_n,
    output logic             de,
    output logic [PIX_W-1:0] pix
);
    localparam int HS_LO = H_VIS + H_FP;
    localparam int HS_HI = HS_LO + H_SYNC;
    localparam int VS_LO = V_VIS + V_FP;
    localparam int VS_HI = VS_LO + V_SYNC;

    typedef struct packed {
        logic [XW-1:0] x;
        logic [YW-1:0] y;
        vgu_sync_t     s;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d.x      = x;
        st_d.y      = y;
        st_d.s.de   = (x < XW'(H_VIS)) && (y < YW'(V_VIS));
        st_d.s.hs_n = !in_span(16'(x), 16'(HS_LO), 16'(HS_HI));
        st_d.s.vs_n = !in_span(16'(y), 16'(VS_LO), 16'(VS_HI));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.x <= XW'(H_TOT - 1);
            st_q.y <= YW'(V_TOT - 1);
            st_q.s <= SYNC_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign x_o  = st_q.x;
    assign y_o  = st_q.y;
    assign hs_n = st_q.s.hs_n;
    assign vs_n = st_q.s.vs_n;
    assign de   = st_q.s.de;
    assign pix  = st_q.s.de ? rd_data : '0;
endmodule

// File: rtl/vga_upscaler.sv
module vga_upscaler #(
    parameter int SRC_W      = 80,
    parameter int SRC_H      = 60,
    parameter int SCALE_LOG2 = 3,
    parameter int PIX_W      = 8,
    parameter int H_FP       = 16,
    parameter int H_SYNC     = 96,
    parameter int H_BP       = 48,
    parameter int V_FP       = 10,
    parameter int V_SYNC     = 2,
    parameter int V_BP       = 33,
    // derived values, left at their defaults
    parameter int H_VIS      = SRC_W << SCALE_LOG2,
    parameter int V_VIS      = SRC_H << SCALE_LOG2,
    parameter int H_TOT      = H_VIS + H_FP + H_SYNC + H_BP,
    parameter int V_TOT      = V_VIS + V_FP + V_SYNC + V_BP,
    parameter int XW         = $clog2(H_TOT),
    parameter int YW         = $clog2(V_TOT),
    parameter int AW         = $clog2(SRC_W * SRC_H)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [AW-1:0]    rd_addr_o,
    input  logic [PIX_W-1:0] rd_data_i,
    output logic             hsync_n_o,
    output logic             vsync_n_o,
    output logic             de_o,
    output logic [XW-1:0]    x_o,
    output logic [YW-1:0]    y_o,
    output logic [PIX_W-1:0] pix_o
);
    logic [XW-1:0] cnt_x;
    logic [YW-1:0] cnt_y;
    logic          line_last;
    logic          frame_last;

    vgu_raster #(.H_TOT(H_TOT), .V_TOT(V_TOT), .XW(XW), .YW(YW)) u_raster (
        .clk        (clk),
        .rst_n      (rst_n),
        .x          (cnt_x),
        .y          (cnt_y),
        .line_last  (line_last),
        .frame_last (frame_last)
    );

    vgu_fetch #(
        .SRC_W(SRC_W), .SCALE_LOG2(SCALE_LOG2), .H_VIS(H_VIS), .V_VIS(V_VIS),
        .XW(XW), .YW(YW), .AW(AW)
    ) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .x          (cnt_x),
        .y          (cnt_y),
        .line_last  (line_last),
        .frame_last (frame_last),
        .rd_addr    (rd_addr_o)
    );

    vgu_out_stage #(
        .H_VIS(H_VIS), .V_VIS(V_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC),
        .V_FP(V_FP), .V_SYNC(V_SYNC), .H_TOT(H_TOT), .V_TOT(V_TOT),
        .XW(XW), .YW(YW), .PIX_W(PIX_W)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .x       (cnt_x),
        .y       (cnt_y),
        .rd_data (rd_data_i),
        .x_o     (x_o),
        .y_o     (y_o),
        .hs_n    (hsync_n_o),
        .vs_n    (vsync_n_o),
        .de      (de_o),
        .pix     (pix_o)
    );
endmodule

// File: rtl/vgu_checker.sv
module vgu_checker #(
    parameter int H_VIS  = 640,
    parameter int V_VIS  = 480,
    parameter int H_FP   = 16,
    parameter int H_SYNC = 96,
    parameter int V_FP   = 10,
    parameter int V_SYNC = 2,
    parameter int H_TOT  = 800,
    parameter int V_TOT  = 525,
    parameter int XW     = 10,
    parameter int YW     = 10,
    parameter int AW     = 13,
    parameter int PIX_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [XW-1:0]    x,
    input logic [YW-1:0]    y,
    input logic             hs_n,
    input logic             vs_n,
    input logic             de,
    input logic [AW-1:0]    rd_addr,
    input logic [PIX_W-1:0] pix
);
    localparam int HS_LO = H_VIS + H_FP;
    localparam int HS_HI = HS_LO + H_SYNC;
    localparam int VS_LO = V_VIS + V_FP;
    localparam int VS_HI = VS_LO + V_SYNC;

    assert_hsync_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_n |-> (x >= XW'(HS_LO) && x < XW'(HS_HI)));

    assert_vsync_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !vs_n |-> (y >= YW'(VS_LO) && y < YW'(VS_HI)));

    assert_de_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (x < XW'(H_VIS) && y < YW'(V_VIS)));

    assert_black_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> (pix == '0));

    assert_x_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (x != XW'(H_TOT - 1)) |=> (x == $past(x) + XW'(1)));

    assert_x_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (x == XW'(H_TOT - 1)) |=> (x == '0));

    assert_y_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (x == XW'(H_TOT - 1) && y != YW'(V_TOT - 1)) |=> (y == $past(y) + YW'(1)));

    assert_addr_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr != '0) |=> de);
endmodule

bind vga_upscaler vgu_checker #(
    .H_VIS(H_VIS), .V_VIS(V_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC),
    .V_FP(V_FP), .V_SYNC(V_SYNC), .H_TOT(H_TOT), .V_TOT(V_TOT),
    .XW(XW), .YW(YW), .AW(AW), .PIX_W(PIX_W)
) u_vgu_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .x       (x_o),
    .y       (y_o),
    .hs_n    (hsync_n_o),
    .vs_n    (vsync_n_o),
    .de      (de_o),
    .rd_addr (rd_addr_o),
    .pix     (pix_o)
);

// File: tb/vga_upscaler_tb.sv
module vga_upscaler_tb;
    // reduced geometry so that several whole frames fit the run
    localparam int SW = 8, SH = 6, SL = 3, PW = 8;
    localparam int HFP = 4, HSY = 8, HBP = 4, VFP = 2, VSY = 2, VBP = 3;
    localparam int HV = SW << SL, VV = SH << SL;
    localparam int HT = HV + HFP + HSY + HBP, VT = VV + VFP + VSY + VBP;
    localparam int XW = $clog2(HT), YW = $clog2(VT), AW = $clog2(SW * SH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] rd_addr;
    logic [PW-1:0] rd_data = '0;
    logic hs_n, vs_n, de;
    logic [XW-1:0] x;
    logic [YW-1:0] y;
    logic [PW-1:0] pix;

    int n_chk = 0, n_err = 0;
    int ex, ey;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vga_upscaler #(
        .SRC_W(SW), .SRC_H(SH), .SCALE_LOG2(SL), .PIX_W(PW),
        .H_FP(HFP), .H_SYNC(HSY), .H_BP(HBP), .V_FP(VFP), .V_SYNC(VSY), .V_BP(VBP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .hsync_n_o(hs_n), .vsync_n_o(vs_n), .de_o(de), .x_o(x), .y_o(y), .pix_o(pix)
    );

    function automatic int mem_val(input int a);
        return (a * 29 + 7) % 256;
    endfunction

    // synchronous-read frame store
    always @(posedge clk) rd_data <= PW'(mem_val(int'(rd_addr)));

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s at (%0d,%0d): actual=%0d expected=%0d", tag, ex, ey, act, exp);
        end
    endtask

    task automatic compare_all(input string pre);
        int nx, ny;
        bit e_de, e_hs, e_vs, nvis;
        int e_pix, e_addr;
        e_de  = (ex < HV) && (ey < VV);
        e_hs  = !((ex >= HV + HFP) && (ex < HV + HFP + HSY));
        e_vs  = !((ey >= VV + VFP) && (ey < VV + VFP + VSY));
        e_pix = e_de ? mem_val((ey >> SL) * SW + (ex >> SL)) : 0;
        nx = (ex == HT - 1) ? 0 : ex + 1;
        ny = (ex == HT - 1) ? ((ey == VT - 1) ? 0 : ey + 1) : ey;
        nvis = (nx < HV) && (ny < VV);
        e_addr = nvis ? (ny >> SL) * SW + (nx >> SL) : 0;
        check({pre, "R5 x"}, int'(x), ex);
        check({pre, "R5 y"}, int'(y), ey);
        check({pre, "R1 hsync"}, int'(hs_n), int'(e_hs));
        check({pre, "R2 vsync"}, int'(vs_n), int'(e_vs));
        check({pre, "R3 de"}, int'(de), int'(e_de));
        check({pre, e_de ? "R7 pixel" : "R4 pixel"}, int'(pix), e_pix);
        check({pre, nvis ? "R6 addr" : "R8 addr"}, int'(rd_addr), e_addr);
    endtask

    task automatic run(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk);
            if (ex == HT - 1) begin
                ex = 0;
                ey = (ey == VT - 1) ? 0 : ey + 1;
            end else begin
                ex = ex + 1;
            end
            @(negedge clk);
            compare_all("");
        end
    endtask

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        ex = HT - 1; ey = VT - 1;
        compare_all("R9 ");
        rst_n = 1'b1;
        run(2 * HT * VT + 300);
        // R9: reset in the middle of a frame, then restart from the top
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        ex = HT - 1; ey = VT - 1;
        compare_all("R9 ");
        @(negedge clk);
        rst_n = 1'b1;
        run(HT * 12);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule